// File: doc/BRIEF.md
# Flash Emulation RAM Overlay Controller

The block sits on the CPU address path in front of the on-chip flash and RAM arrays. It decodes each CPU request into a flash chip select or a RAM chip select, each with an array-relative address. Software can turn on an overlay that maps one of the eight 4 KB flash blocks at the bottom of flash onto a fixed 4 KB RAM window. Code, constants and the exception vectors can then be tuned in RAM before they are written to flash. While the overlay is on, the storage is reachable both at its RAM address and at the selected flash block address.

The block also holds the two flash mode request bits, program and erase. These bits are always stored as written. Their outgoing mode-enable lines are forced low for as long as the overlay is enabled, whichever block is selected, so flash cannot be altered during emulation. Clearing the enable bit releases both the overlay and the protection.

Top module: `flash_emu_overlay`

## Requirements
- R1: After reset `ctrl_q_o` and `pe_q_o` are zero, so the overlay is off and both mode-enable outputs are low.
- R2: A write with `ctrl_we_i` loads `ctrl_wdata_i` into the control register, visible on `ctrl_q_o` after the next rising clock edge. Bit 3 is the overlay enable and bits 2:0 are the block select. Without `ctrl_we_i` the register holds its value.
- R3: A request at an address below 0x040000 that is not redirected asserts `flash_cs_o` in the same cycle, with `flash_addr_o` = address[17:0].
- R4: A request in 0xFFE000..0xFFFFFF asserts `ram_cs_o` in the same cycle, with `ram_addr_o` = address[12:0].
- R5: When the enable bit is 1 and address[17:12] equals {3'b000, select}, the request is redirected. `flash_cs_o` is 0, `ram_cs_o` is 1 and `ram_addr_o` = {1'b0, address[11:0]}. Select code n picks the block at n*0x1000.
- R6: With the overlay enabled, flash addresses outside the selected block go to flash unchanged. This covers the other small blocks, the blocks from 0x008000 up, and addresses whose bits [17:15] are nonzero.
- R7: Exception vector fetches at the bottom of block 0 are redirected to the RAM window when the select is 000 and the overlay is enabled.
- R8: A write with `pe_we_i` loads `pe_wdata_i` into `pe_q_o` after the next edge, whatever the enable bit holds. Bit 0 is the program request and bit 1 is the erase request.
- R9: While the enable bit is 1, `prog_en_o` and `erase_en_o` are 0 for every select value. While the enable bit is 0 they equal `pe_q_o[0]` and `pe_q_o[1]`.
- R10: After the enable bit is cleared, the next request to the formerly overlaid block goes to flash, and the mode-enable outputs follow the stored request bits again.
- R11: Without `cpu_req_i`, or at an address in neither region, both chip selects are 0. An address output whose chip select is 0 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Control write data: bit 3 enable, bits 2:0 block select |
| pe_we_i | input | 1 | Mode request register write strobe |
| pe_wdata_i | input | 2 | Mode request data: bit 0 program, bit 1 erase |
| cpu_req_i | input | 1 | CPU access request |
| cpu_addr_i | input | 24 | CPU byte address |
| ctrl_q_o | output | 4 | Control register contents |
| pe_q_o | output | 2 | Stored mode request bits |
| flash_cs_o | output | 1 | Flash array select |
| flash_addr_o | output | 18 | Flash array address |
| ram_cs_o | output | 1 | RAM array select |
| ram_addr_o | output | 13 | RAM array address |
| prog_en_o | output | 1 | Program mode enable to flash |
| erase_en_o | output | 1 | Erase mode enable to flash |

## Verification
Chip selects and array addresses are combinational from the request and the registered control state. The bench therefore checks them in the same cycle it applies an address, after any register write has crossed one rising edge. Register contents and the mode-enable outputs change one edge after a write strobe. Inputs are driven and outputs are compared on falling edges, so every check sits half a period after the edge that should have produced it.

// File: rtl/feo_pkg.sv
package feo_pkg;
  localparam int ADDR_W   = 24;
  localparam int FLASH_AW = 18;
  localparam int BLK_AW   = 12;
  localparam int SEL_W    = 3;
  localparam int RAM_AW   = 13;
  localparam logic [ADDR_W-1:0] RAM_BASE = 24'hFFE000;
  localparam int FIELD_W  = FLASH_AW - BLK_AW;
  localparam int CTRL_W   = SEL_W + 1;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/feo_ctrl_regs.sv
module feo_ctrl_regs
  import feo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              pe_we_i,
  input  logic [1:0]        pe_wdata_i,
  output ctrl_t             ctrl_o,
  output logic [1:0]        pe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      pe_o   <= '0;
    end else begin
      if (ctrl_we_i) ctrl_o <= ctrl_t'(ctrl_wdata_i);
      if (pe_we_i)   pe_o   <= pe_wdata_i;
    end
  end

  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_o));
  p_pe_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_we_i |=> pe_o == $past(pe_wdata_i));
endmodule

// File: rtl/feo_addr_map.sv
module feo_addr_map
  import feo_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  ctrl_t               ctrl_i,
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                flash_cs_o,
  output logic [FLASH_AW-1:0] flash_addr_o,
  output logic                ram_cs_o,
  output logic [RAM_AW-1:0]   ram_addr_o
);
  logic in_flash, in_ram, hit;

  assign in_flash = (addr_i[ADDR_W-1:FLASH_AW] == '0);
  assign in_ram   = (addr_i[ADDR_W-1:RAM_AW] == RAM_BASE[ADDR_W-1:RAM_AW]);
  // overlay hit: enabled and block index matches the select
  assign hit      = ctrl_i.en && in_flash &&
                    (addr_i[FLASH_AW-1:BLK_AW] == FIELD_W'(ctrl_i.sel));

  always_comb begin
    flash_cs_o   = 1'b0;
    flash_addr_o = '0;
    ram_cs_o     = 1'b0;
    ram_addr_o   = '0;
    if (req_i) begin
      if (hit) begin
        ram_cs_o   = 1'b1;
        ram_addr_o = RAM_AW'(addr_i[BLK_AW-1:0]);
      end else if (in_flash) begin
        flash_cs_o   = 1'b1;
        flash_addr_o = addr_i[FLASH_AW-1:0];
      end else if (in_ram) begin
        ram_cs_o   = 1'b1;
        ram_addr_o = addr_i[RAM_AW-1:0];
      end
    end
  end

  p_cs_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flash_cs_o, ram_cs_o}));
  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !flash_cs_o && !ram_cs_o);
  p_no_flash_when_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ctrl_i.en && in_flash) |-> flash_cs_o && !ram_cs_o);
endmodule

// File: rtl/feo_pe_gate.sv
module feo_pe_gate
  import feo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ctrl_t      ctrl_i,
  input  logic [1:0] pe_i,
  output logic [1:0] mode_en_o
);
  for (genvar m = 0; m < 2; m++) begin : g_mode
    assign mode_en_o[m] = pe_i[m] & ~ctrl_i.en;
  end

  p_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.en |-> mode_en_o == 2'b00);
endmodule

// File: rtl/flash_emu_overlay.sv
module flash_emu_overlay
  import feo_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_we_i,
  input  logic [CTRL_W-1:0]   ctrl_wdata_i,
  input  logic                pe_we_i,
  input  logic [1:0]          pe_wdata_i,
  input  logic                cpu_req_i,
  input  logic [ADDR_W-1:0]   cpu_addr_i,
  output logic [CTRL_W-1:0]   ctrl_q_o,
  output logic [1:0]          pe_q_o,
  output logic                flash_cs_o,
  output logic [FLASH_AW-1:0] flash_addr_o,
  output logic                ram_cs_o,
  output logic [RAM_AW-1:0]   ram_addr_o,
  output logic                prog_en_o,
  output logic                erase_en_o
);
  ctrl_t      ctrl;
  logic [1:0] pe, mode_en;

  feo_ctrl_regs u_regs (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .pe_we_i, .pe_wdata_i,
    .ctrl_o(ctrl), .pe_o(pe)
  );

  feo_addr_map u_map (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .req_i(cpu_req_i), .addr_i(cpu_addr_i),
    .flash_cs_o, .flash_addr_o, .ram_cs_o, .ram_addr_o
  );

  feo_pe_gate u_gate (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .pe_i(pe), .mode_en_o(mode_en)
  );

  assign ctrl_q_o   = ctrl;
  assign pe_q_o     = pe;
  assign prog_en_o  = mode_en[0];
  assign erase_en_o = mode_en[1];

  p_redirect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && ctrl_q_o[CTRL_W-1] && cpu_addr_i[ADDR_W-1:BLK_AW] == {9'd0, ctrl_q_o[SEL_W-1:0]})
      |-> ram_cs_o && !flash_cs_o && ram_addr_o[RAM_AW-1] == 1'b0);
  p_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q_o[CTRL_W-1] |-> {erase_en_o, prog_en_o} == pe_q_o);
endmodule

// File: tb/flash_emu_overlay_tb.sv
module flash_emu_overlay_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 14;
  // {ctrl[3:0], addr[23:0], flash_cs, ram_cs, ram_addr[12:0], flash_addr[17:0]}
  localparam logic [60:0] VEC [NV] = '{
    {4'h0, 24'h000123, 1'b1, 1'b0, 13'h0000, 18'h00123},  // R3
    {4'h8, 24'h000123, 1'b0, 1'b1, 13'h0123, 18'h00000},  // R5
    {4'h8, 24'h000004, 1'b0, 1'b1, 13'h0004, 18'h00000},  // R7 vector
    {4'h8, 24'h001000, 1'b1, 1'b0, 13'h0000, 18'h01000},  // R6
    {4'hD, 24'h005ABC, 1'b0, 1'b1, 13'h0ABC, 18'h00000},  // R5 sel5
    {4'hD, 24'h000ABC, 1'b1, 1'b0, 13'h0000, 18'h00ABC},  // R6
    {4'hF, 24'h007FFF, 1'b0, 1'b1, 13'h0FFF, 18'h00000},  // R5 sel7
    {4'hF, 24'h008000, 1'b1, 1'b0, 13'h0000, 18'h08000},  // R6 large block
    {4'h9, 24'h031000, 1'b1, 1'b0, 13'h0000, 18'h31000},  // R6 upper bits
    {4'h5, 24'h005ABC, 1'b1, 1'b0, 13'h0000, 18'h05ABC},  // R10 disabled
    {4'h8, 24'hFFE123, 1'b0, 1'b1, 13'h0123, 18'h00000},  // R4
    {4'h8, 24'hFFF010, 1'b0, 1'b1, 13'h1010, 18'h00000},  // R4
    {4'h0, 24'h040000, 1'b0, 1'b0, 13'h0000, 18'h00000},  // R11
    {4'h8, 24'h800000, 1'b0, 1'b0, 13'h0000, 18'h00000}   // R11
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0, pe_we_i = 1'b0, cpu_req_i = 1'b0;
  logic [3:0]  ctrl_wdata_i = '0;
  logic [1:0]  pe_wdata_i = '0;
  logic [23:0] cpu_addr_i = '0;
  logic [3:0]  ctrl_q_o;
  logic [1:0]  pe_q_o;
  logic        flash_cs_o, ram_cs_o, prog_en_o, erase_en_o;
  logic [17:0] flash_addr_o;
  logic [12:0] ram_addr_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  flash_emu_overlay dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [3:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic wr_pe(logic [1:0] v);
    pe_we_i = 1'b1; pe_wdata_i = v;
    @(negedge clk_i);
    pe_we_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 ctrl", 64'(ctrl_q_o), 64'h0);
    check("R1 pe", 64'(pe_q_o), 64'h0);
    check("R1 modes", 64'({erase_en_o, prog_en_o}), 64'h0);

    cpu_req_i = 1'b1;
    for (int i = 0; i < NV; i++) begin
      wr_ctrl(VEC[i][60:57]);
      cpu_addr_i = VEC[i][56:33];
      #1;
      check("R2 ctrl load", 64'(ctrl_q_o), 64'(VEC[i][60:57]));
      check("R3-5 flash_cs", 64'(flash_cs_o), 64'(VEC[i][32]));
      check("R4/R5 ram_cs", 64'(ram_cs_o), 64'(VEC[i][31]));
      check("R4/R5 ram_addr", 64'(ram_addr_o), 64'(VEC[i][30:18]));
      check("R3/R6 flash_addr", 64'(flash_addr_o), 64'(VEC[i][17:0]));
    end

    // R11: no request, no select
    wr_ctrl(4'h8);
    cpu_addr_i = 24'h000010;
    cpu_req_i = 1'b0;
    #1;
    check("R11 idle", 64'({flash_cs_o, ram_cs_o}), 64'h0);
    cpu_req_i = 1'b1;

    // R2 hold without strobe
    @(negedge clk_i);
    check("R2 hold", 64'(ctrl_q_o), 64'h8);

    // R8/R9 mode gating
    wr_ctrl(4'h0);
    wr_pe(2'b01);
    check("R9 prog follows", 64'({erase_en_o, prog_en_o}), 64'b01);
    wr_pe(2'b10);
    check("R9 erase follows", 64'({erase_en_o, prog_en_o}), 64'b10);
    wr_ctrl(4'h8);
    check("R9 blocked sel0", 64'({erase_en_o, prog_en_o}), 64'b00);
    check("R8 stored", 64'(pe_q_o), 64'b10);
    wr_pe(2'b11);
    check("R8 accept while enabled", 64'(pe_q_o), 64'b11);
    check("R9 blocked after write", 64'({erase_en_o, prog_en_o}), 64'b00);
    wr_ctrl(4'hE);
    check("R9 blocked sel6", 64'({erase_en_o, prog_en_o}), 64'b00);

    // R10 release
    cpu_addr_i = 24'h006040;
    #1;
    check("R10 before release ram_cs", 64'(ram_cs_o), 64'h1);
    wr_ctrl(4'h6);
    #1;
    check("R10 flash again", 64'({flash_cs_o, ram_cs_o}), 64'b10);
    check("R10 flash addr", 64'(flash_addr_o), 64'h06040);
    check("R10 modes released", 64'({erase_en_o, prog_en_o}), 64'b11);

    // R1 asynchronous reset clears state
    rst_ni = 1'b0;
    #1;
    check("R1 async ctrl", 64'(ctrl_q_o), 64'h0);
    check("R1 async pe", 64'(pe_q_o), 64'h0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule